// File: doc/BRIEF.md
# Single-Buffer Packet DMA Engine

This block is the data mover of a network interface. Software places a packet in host memory, writes the buffer's base address and byte length into two registers, and then writes a start bit. The engine fetches the bytes over a byte-wide memory port and presents them on an outgoing byte stream. The final byte is marked, and a transmit interrupt follows once that byte has been taken.

Reception works the other way round. Software gives a second base and length and arms the receiver. The next packet on the incoming byte stream is written to memory, and a receive interrupt is raised. Bytes beyond the programmed length are discarded and flagged. A packet that begins while the receiver is not armed is thrown away whole and counted.

Both directions share one memory port. Receive writes take precedence over transmit reads.

Top module: `nic_dma_core`

## Requirements
- R1: After reset, no memory request, outgoing byte or interrupt is active, and the status word (offset 0x18) reads 0.
- R2: A transmit of length N from base B sends the bytes at memory addresses B..B+N-1 in ascending order. The last of them carries `tx_last`. Data and `tx_last` stay unchanged while `tx_ready` is low.
- R3: `irq_tx` goes high the cycle after the final byte is accepted. Busy (status bit 0, also the transmit trigger readback) is then 0. The register offsets are: transmit base 0x00, transmit length 0x04, transmit trigger 0x08, receive base 0x0C, receive length 0x10, receive arm 0x14, status 0x18, interrupt clear 0x1C.
- R4: Base and length registers read back the last value written.
- R5: Writing 1 to the transmit trigger while a transmit is busy has no effect on the transfer and sets the error flag (status bit 4).
- R6: A transmit started with length 0 raises `irq_tx` on the next cycle and sends no byte.
- R7: Interrupts are levels that stay high until a 1 is written to their bit of the clear register: bit 0 clears `irq_tx`, bit 1 clears `irq_rx`, bit 2 clears the error flag and bit 3 clears the overflow flag.
- R8: An armed receive stores byte i of the packet at base+i. When all bytes are in memory, `irq_rx` rises, the armed bit (status bit 1) clears, and status bits 31:16 hold the number of bytes stored.
- R9: A packet longer than the receive length L has only its first L bytes stored. The overflow flag (status bit 5) is set and the stored count is L.
- R10: A packet whose first byte arrives while the receiver is not armed writes nothing and raises no interrupt. This holds even if the receiver is armed before the packet ends. The drop count (status bits 15:8) increases by one per such packet.
- R11: Each `dma_req`/`dma_gnt` handshake moves exactly one byte. A request stays up until it is granted. Transmit and receive running together both complete correctly.
- R12: Writing 1 to the receive arm register while already armed leaves reception unchanged and sets the error flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |
| dma_req | output | 1 | Memory access request |
| dma_we | output | 1 | Request is a write |
| dma_addr | output | AW | Byte address |
| dma_wdata | output | 8 | Write byte |
| dma_rdata | input | 8 | Read byte, valid while granted |
| dma_gnt | input | 1 | Request accepted this cycle |
| tx_valid | output | 1 | Outgoing byte present |
| tx_data | output | 8 | Outgoing byte |
| tx_last | output | 1 | Final byte of the packet |
| tx_ready | input | 1 | Sink accepts outgoing byte |
| rx_valid | input | 1 | Incoming byte present |
| rx_data | input | 8 | Incoming byte |
| rx_last | input | 1 | Final byte of the incoming packet |
| rx_ready | output | 1 | Engine accepts incoming byte |
| irq_tx | output | 1 | Transmit-complete interrupt |
| irq_rx | output | 1 | Receive-complete interrupt |

## Verification
The hardest case to reach is a packet that began unarmed and must keep being dropped after software arms the receiver partway through it. The bench feeds the first byte by hand, performs the arm write between bytes, and then finishes the packet. It then confirms that the drop count rose, that no memory write appeared, and that the receiver is still armed for the next packet. A second hard case is a memory port contended by both directions. This is reached by starting a transmit and feeding a receive packet together while the grant line is stalled on a fixed pattern.

// File: rtl/nic_dma_core.sv
`timescale 1ns/1ps
module nic_dma_core #(
  parameter int AW = 32,
  parameter int LW = 16,
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_we,
  input  logic [4:0]    reg_addr,
  input  logic [31:0]   reg_wdata,
  output logic [31:0]   reg_rdata,
  output logic          dma_req,
  output logic          dma_we,
  output logic [AW-1:0] dma_addr,
  output logic [7:0]    dma_wdata,
  input  logic [7:0]    dma_rdata,
  input  logic          dma_gnt,
  output logic          tx_valid,
  output logic [7:0]    tx_data,
  output logic          tx_last,
  input  logic          tx_ready,
  input  logic          rx_valid,
  input  logic [7:0]    rx_data,
  input  logic          rx_last,
  output logic          rx_ready,
  output logic          irq_tx,
  output logic          irq_rx
);
  localparam logic [4:0] A_TXB = 5'h00, A_TXL = 5'h04, A_TXT = 5'h08, A_RXB = 5'h0C,
                         A_RXL = 5'h10, A_RXA = 5'h14, A_STA = 5'h18, A_CLR = 5'h1C;

  logic [AW-1:0] tx_base, rx_base, tx_ptr, rx_waddr;
  logic [LW-1:0] tx_len, rx_len, tx_rem, rx_cnt;
  logic [CW-1:0] drops;
  logic [7:0]    tx_byte, rx_byte;
  logic tx_busy, tx_full, tx_end, rx_armed, rx_full, rx_end, in_pkt, pkt_drop, err, ovf;

  wire       go_wr   = reg_we && reg_addr == A_TXT && reg_wdata[0];
  wire       arm_wr  = reg_we && reg_addr == A_RXA && reg_wdata[0];
  wire [3:0] clr     = (reg_we && reg_addr == A_CLR) ? reg_wdata[3:0] : 4'b0;
  wire       tx_want = tx_busy && !tx_full && tx_rem != '0;
  wire       tx_fetch = tx_want && !rx_full && dma_gnt;
  wire       tx_done = tx_full && tx_ready && tx_end;
  wire       tx_zero = go_wr && !tx_busy && tx_len == '0;
  wire       rx_take = rx_valid && rx_ready;
  wire       dropping = in_pkt ? pkt_drop : !rx_armed;
  wire       rx_room = rx_cnt < rx_len;
  wire       rx_store = rx_take && !dropping && rx_room;
  wire       rx_complete = rx_end && !rx_full;

  assign dma_req   = rx_full || tx_want;
  assign dma_we    = rx_full;
  assign dma_addr  = rx_full ? rx_waddr : tx_ptr;
  assign dma_wdata = rx_byte;
  assign tx_valid  = tx_full;
  assign tx_data   = tx_byte;
  assign tx_last   = tx_full && tx_end;
  assign rx_ready  = !rx_full && !rx_end;

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      A_TXB: reg_rdata = 32'(tx_base);
      A_TXL: reg_rdata = 32'(tx_len);
      A_TXT: reg_rdata = {31'b0, tx_busy};
      A_RXB: reg_rdata = 32'(rx_base);
      A_RXL: reg_rdata = 32'(rx_len);
      A_RXA: reg_rdata = {31'b0, rx_armed};
      A_STA: reg_rdata = {16'(rx_cnt), 8'(drops), 2'b0, ovf, err, irq_rx, irq_tx, rx_armed, tx_busy};
      default: reg_rdata = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_base <= '0; tx_len <= '0; rx_base <= '0; rx_len <= '0;
    end else if (reg_we) begin
      if (reg_addr == A_TXB) tx_base <= reg_wdata[AW-1:0];
      if (reg_addr == A_TXL) tx_len  <= reg_wdata[LW-1:0];
      if (reg_addr == A_RXB) rx_base <= reg_wdata[AW-1:0];
      if (reg_addr == A_RXL) rx_len  <= reg_wdata[LW-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_busy <= 1'b0; tx_full <= 1'b0; tx_end <= 1'b0;
      tx_ptr <= '0; tx_rem <= '0; tx_byte <= '0; irq_tx <= 1'b0;
    end else begin
      if (go_wr && !tx_busy && tx_len != '0) begin
        tx_busy <= 1'b1;
        tx_ptr  <= tx_base;
        tx_rem  <= tx_len;
      end
      if (tx_fetch) begin
        tx_full <= 1'b1;
        tx_byte <= dma_rdata;
        tx_end  <= tx_rem == LW'(1);
        tx_ptr  <= tx_ptr + 1'b1;
        tx_rem  <= tx_rem - 1'b1;
      end
      if (tx_full && tx_ready) tx_full <= 1'b0;
      if (tx_done) tx_busy <= 1'b0;
      if (tx_done || tx_zero) irq_tx <= 1'b1;
      else if (clr[0]) irq_tx <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_armed <= 1'b0; rx_full <= 1'b0; rx_end <= 1'b0; in_pkt <= 1'b0; pkt_drop <= 1'b0;
      rx_cnt <= '0; rx_waddr <= '0; rx_byte <= '0; drops <= '0;
      irq_rx <= 1'b0; err <= 1'b0; ovf <= 1'b0;
    end else begin
      if (arm_wr && !rx_armed) begin
        rx_armed <= 1'b1;
        rx_cnt   <= '0;
      end
      if (rx_take) begin
        in_pkt <= !rx_last;
        if (!in_pkt) pkt_drop <= !rx_armed;
        if (rx_last && dropping) drops <= drops + 1'b1;
        if (rx_last && !dropping) rx_end <= 1'b1;
      end
      if (rx_store) begin
        rx_full  <= 1'b1;
        rx_byte  <= rx_data;
        rx_waddr <= rx_base + AW'(rx_cnt);
        rx_cnt   <= rx_cnt + 1'b1;
      end
      if (rx_full && dma_gnt) rx_full <= 1'b0;
      if (rx_complete) begin
        rx_armed <= 1'b0;
        rx_end   <= 1'b0;
      end
      if (rx_complete) irq_rx <= 1'b1;
      else if (clr[1]) irq_rx <= 1'b0;
      if ((go_wr && tx_busy) || (arm_wr && rx_armed)) err <= 1'b1;
      else if (clr[2]) err <= 1'b0;
      if (rx_take && !dropping && !rx_room) ovf <= 1'b1;
      else if (clr[3]) ovf <= 1'b0;
    end
  end
endmodule

// File: rtl/nic_dma_core_chk.sv
`timescale 1ns/1ps
module nic_dma_core_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       reg_we,
  input logic [4:0] reg_addr,
  input logic [3:0] clr_bits,
  input logic       dma_req,
  input logic       dma_we,
  input logic       dma_gnt,
  input logic       tx_valid,
  input logic [7:0] tx_data,
  input logic       tx_last,
  input logic       tx_ready,
  input logic       rx_ready,
  input logic       irq_tx,
  input logic       irq_rx,
  input logic       tx_busy,
  input logic       rx_armed
);
  wire clr_wr = reg_we && reg_addr == 5'h1C;

  a_r11_req_held: assert property (@(posedge clk) disable iff (!rst_n)
    dma_req && !dma_gnt |=> dma_req);
  a_r2_tx_hold: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && !tx_ready |=> tx_valid && $stable(tx_data) && $stable(tx_last));
  a_r7_irq_tx_level: assert property (@(posedge clk) disable iff (!rst_n)
    irq_tx && !(clr_wr && clr_bits[0]) |=> irq_tx);
  a_r7_irq_rx_level: assert property (@(posedge clk) disable iff (!rst_n)
    irq_rx && !(clr_wr && clr_bits[1]) |=> irq_rx);
  a_r8_rx_stall: assert property (@(posedge clk) disable iff (!rst_n)
    dma_req && dma_we |-> !rx_ready);
  a_r3_irq_idle: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_tx) |-> !tx_busy);
  a_r8_irq_disarm: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_rx) |-> !rx_armed);
endmodule

bind nic_dma_core nic_dma_core_chk u_chk (
  .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr), .clr_bits(reg_wdata[3:0]),
  .dma_req(dma_req), .dma_we(dma_we), .dma_gnt(dma_gnt), .tx_valid(tx_valid),
  .tx_data(tx_data), .tx_last(tx_last), .tx_ready(tx_ready), .rx_ready(rx_ready),
  .irq_tx(irq_tx), .irq_rx(irq_rx), .tx_busy(tx_busy), .rx_armed(rx_armed)
);

// File: tb/tb_nic_dma_core.sv
`timescale 1ns/1ps
module tb_nic_dma_core;
  logic clk = 0, rst_n = 0;
  logic reg_we = 0; logic [4:0] reg_addr = 0; logic [31:0] reg_wdata = 0; logic [31:0] reg_rdata;
  logic dma_req, dma_we, dma_gnt = 1; logic [31:0] dma_addr; logic [7:0] dma_wdata, dma_rdata;
  logic tx_valid, tx_last, tx_ready = 1; logic [7:0] tx_data;
  logic rx_valid = 0, rx_last = 0, rx_ready; logic [7:0] rx_data = 0;
  logic irq_tx, irq_rx;
  int checks = 0, fails = 0, cyc = 0;
  bit gnt_stall = 0, tx_hold = 0, tx_bp = 0, finished = 0;
  logic [7:0] mem [256];
  logic [7:0]  txq [$];
  logic [15:0] rxq [$];
  logic [31:0] v;

  nic_dma_core dut (.*);

  always #4 clk = ~clk;
  assign dma_rdata = mem[dma_addr[7:0]];

  always @(posedge clk) begin
    if (dma_req && dma_gnt && dma_we) mem[dma_addr[7:0]] <= dma_wdata;
    #1;
    cyc++;
    dma_gnt = gnt_stall ? (cyc % 3 != 2) : 1'b1;
    tx_ready = tx_hold ? 1'b0 : (tx_bp ? (cyc % 2 == 0) : 1'b1);
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin fails++; $display("FAIL %s actual=%0h expected=%0h", tag, act, exp); end
  endtask

  always @(negedge clk) begin
    if (rst_n && tx_valid && tx_ready) begin
      if (txq.size() == 0) chk(0, "R2 unexpected tx byte", tx_data, 0);
      else begin
        logic [7:0] e; e = txq.pop_front();
        chk(tx_data == e, "R2 tx byte", tx_data, e);
        chk(tx_last == (txq.size() == 0), "R2 tx_last", tx_last, txq.size() == 0);
      end
    end
    if (rst_n && dma_req && dma_gnt && dma_we) begin
      if (rxq.size() == 0) chk(0, "R10 unexpected mem write", {dma_addr[7:0], dma_wdata}, 0);
      else begin
        logic [15:0] e; e = rxq.pop_front();
        chk({dma_addr[7:0], dma_wdata} == e, "R8 mem write", {dma_addr[7:0], dma_wdata}, e);
      end
    end
  end

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(posedge clk); #2; reg_we = 1; reg_addr = a; reg_wdata = d;
    @(posedge clk); #2; reg_we = 0;
  endtask
  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    @(posedge clk); #2; reg_addr = a; @(negedge clk); d = reg_rdata;
  endtask
  task automatic push_tx(input int base, input int n);
    for (int i = 0; i < n; i++) txq.push_back(mem[(base + i) % 256]);
  endtask
  task automatic push_rx(input int base, input logic [7:0] b0, input int n);
    for (int i = 0; i < n; i++) rxq.push_back({8'(base + i), 8'(b0 + i)});
  endtask
  task automatic send_byte(input logic [7:0] d, input bit last);
    @(posedge clk); #2; rx_valid = 1; rx_data = d; rx_last = last;
    forever begin @(negedge clk); if (rx_ready) break; end
    @(posedge clk); #2; rx_valid = 0; rx_last = 0;
  endtask
  task automatic send_pkt(input logic [7:0] b0, input int n);
    for (int i = 0; i < n; i++) send_byte(8'(b0 + i), i == n - 1);
  endtask
  task automatic wait_irq(input bit which, input string tag);
    int k = 0;
    while (k < 200) begin @(negedge clk); if ((which ? irq_rx : irq_tx)) break; k++; end
    chk(k < 200, tag, 0, 1);
  endtask

  initial begin
    #(8 * 150000);
    fails++; $display("FAIL watchdog expired");
    if (!finished) begin finished = 1; $display("TB_RESULT checks=%0d failures=%0d", checks, fails); end
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 8'(i * 7 + 3);
    repeat (3) @(posedge clk); #2; rst_n = 1;
    rd(5'h18, v); chk(v == 0, "R1 status", v, 0);
    chk(!dma_req && !tx_valid && !irq_tx && !irq_rx, "R1 outputs idle", {dma_req, tx_valid, irq_tx, irq_rx}, 0);

    wr(5'h00, 32'h10); wr(5'h04, 5);
    rd(5'h00, v); chk(v == 32'h10, "R4 tx base", v, 32'h10);
    rd(5'h04, v); chk(v == 5, "R4 tx length", v, 5);
    push_tx(16, 5); wr(5'h08, 1);
    wait_irq(0, "R3 irq_tx");
    rd(5'h08, v); chk(v == 0, "R3 trigger self-clear", v, 0);
    chk(txq.size() == 0, "R2 all bytes sent", txq.size(), 0);
    repeat (5) @(negedge clk);
    chk(irq_tx == 1, "R7 irq_tx held", irq_tx, 1);
    wr(5'h1C, 1); @(negedge clk);
    chk(irq_tx == 0, "R7 irq_tx cleared", irq_tx, 0);

    tx_hold = 1; gnt_stall = 1;
    wr(5'h00, 32'h30); wr(5'h04, 6); push_tx(48, 6);
    wr(5'h08, 1); wr(5'h08, 1);
    rd(5'h18, v); chk(v[4] == 1, "R5 error on busy trigger", v[4], 1);
    chk(v[0] == 1, "R5 still busy", v[0], 1);
    tx_hold = 0; tx_bp = 1;
    wait_irq(0, "R5 irq_tx after single transfer");
    repeat (4) @(negedge clk);
    chk(txq.size() == 0, "R5 exactly six bytes", txq.size(), 0);
    wr(5'h1C, 32'h5); tx_bp = 0; gnt_stall = 0;

    wr(5'h04, 0); wr(5'h08, 1);
    chk(irq_tx == 1, "R6 zero length irq", irq_tx, 1);
    chk(tx_valid == 0, "R6 no byte", tx_valid, 0);
    wr(5'h1C, 1);

    wr(5'h0C, 32'h80); wr(5'h10, 8); wr(5'h14, 1);
    wr(5'h14, 1);
    rd(5'h18, v); chk(v[4] == 1 && v[1] == 1, "R12 arm while armed", v[5:0], 6'h12);
    wr(5'h1C, 4);
    push_rx(128, 8'hA0, 4); send_pkt(8'hA0, 4);
    wait_irq(1, "R8 irq_rx");
    rd(5'h18, v);
    chk(v[31:16] == 4, "R8 stored count", v[31:16], 4);
    chk(v[1] == 0 && v[5] == 0, "R8 disarmed, no overflow", v[5:0], 0);
    chk(rxq.size() == 0, "R8 all writes seen", rxq.size(), 0);
    wr(5'h1C, 2);

    wr(5'h0C, 32'h90); wr(5'h10, 3); wr(5'h14, 1);
    push_rx(144, 8'h40, 3); send_pkt(8'h40, 6);
    wait_irq(1, "R9 irq_rx on overflow");
    rd(5'h18, v);
    chk(v[5] == 1, "R9 overflow flag", v[5], 1);
    chk(v[31:16] == 3, "R9 truncated count", v[31:16], 3);
    chk(mem[147] == 8'(147 * 7 + 3), "R9 byte past buffer untouched", mem[147], 8'(147 * 7 + 3));
    wr(5'h1C, 32'hA);

    send_pkt(8'h60, 3);
    repeat (3) @(negedge clk);
    rd(5'h18, v); chk(v[15:8] == 1, "R10 drop count", v[15:8], 1);
    chk(irq_rx == 0, "R10 no irq", irq_rx, 0);
    wr(5'h0C, 32'hA0); wr(5'h10, 8);
    send_byte(8'h70, 0); wr(5'h14, 1); send_byte(8'h71, 0); send_byte(8'h72, 1);
    repeat (3) @(negedge clk);
    rd(5'h18, v);
    chk(v[15:8] == 2, "R10 drop while armed mid-packet", v[15:8], 2);
    chk(v[1] == 1 && irq_rx == 0, "R10 still armed, no irq", {v[1], irq_rx}, 2'b10);
    push_rx(160, 8'h20, 2); send_pkt(8'h20, 2);
    wait_irq(1, "R10 next packet stored");
    wr(5'h1C, 2);

    gnt_stall = 1;
    wr(5'h00, 32'h20); wr(5'h04, 4); push_tx(32, 4);
    wr(5'h0C, 32'hC0); wr(5'h10, 4); wr(5'h14, 1); push_rx(192, 8'h50, 4);
    fork
      wr(5'h08, 1);
      send_pkt(8'h50, 4);
    join
    wait_irq(0, "R11 tx done concurrent");
    wait_irq(1, "R11 rx done concurrent");
    repeat (4) @(negedge clk);
    chk(txq.size() == 0 && rxq.size() == 0, "R11 queues drained", txq.size() + rxq.size(), 0);
    chk(dma_req == 0, "R11 port idle", dma_req, 0);

    if (!finished) begin finished = 1; $display("TB_RESULT checks=%0d failures=%0d", checks, fails); end
    $finish;
  end
endmodule